// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a watchdog that runs from the system clock. A 7-bit down-counter steps once per tick. A fixed power-of-two divider makes the tick, and a selectable prescaler divides it further by 1, 2, 4 or 8. The divider depth is 4096 by default. Software reaches the block through a one-cycle register write made of a strobe, a 2-bit select and a 9-bit data word. With that write it programs a window value and a prescaler, starts the watchdog and refreshes the counter.

The block raises a reset request in three cases:
- the counter steps from 0x40 down to 0x3F;
- a refresh arrives while the count is still above the window value;
- a refresh would load a value with bit 6 clear.

An early-warning interrupt is set when the count steps down to 0x40. This leaves software one tick period to refresh or to save state. The reset request is a level held until the reset controller acknowledges it. A sticky flag records that a watchdog reset took place. The system reset leaves that flag alone, and only the power-on reset or a software clear removes it.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_ni` is low and after its release, the count is 0x7F, the window is 0x7F, the prescaler selects divide-by-1, and the watchdog is disabled. `irq_o` and `rst_req_o` are 0.
- R2: A write with select 0 and data bit 7 set enables the watchdog. A later write with bit 7 clear does not disable it. Only `rst_ni` disables it.
- R3: While enabled, the count drops by one every 2^(DIV_LOG2+P) cycles. P is the 2-bit prescaler taken from data bits 8:7 of a select-1 write. The same write takes the window from data bits 6:0.
- R4: A select-0 write (refresh) loads data bits 6:0 into the count and restarts the timebase. The next decrement therefore comes a full tick period after the write.
- R5: While enabled, a tick at count 0x40 moves the count to 0x3F and raises `rst_req_o` in the same clock. No request is raised while the count is 0x40.
- R6: While enabled, a refresh when the count is above the window raises `rst_req_o`. A refresh when the count is at or below the window raises none.
- R7: While enabled, a refresh whose data bit 6 is 0 raises `rst_req_o`.
- R8: `irq_o` is set when an enabled tick moves the count from 0x41 to 0x40. It stays set until a select-2 write with data bit 0 equal to 0. A select-2 write with bit 0 equal to 1 leaves it set.
- R9: Once raised, `rst_req_o` stays high until `rst_ack_i` is sampled high.
- R10: `wdg_rst_flag_o` is set together with every reset request. It survives `rst_ni` and is cleared by `por_ni` or by a select-2 write with data bit 1 set.
- R11: While disabled, the count does not tick, and refreshes load the count without raising a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| por_ni | input | 1 | Asynchronous active-low power-on reset, clears the sticky flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 control/refresh, 1 window and prescaler, 2 flag clears |
| wr_data_i | input | 9 | Write data |
| rst_ack_i | input | 1 | Acknowledge from the reset controller |
| count_o | output | 7 | Current count |
| enabled_o | output | 1 | Watchdog running |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request |
| wdg_rst_flag_o | output | 1 | Sticky watchdog-reset flag |

## Verification
Every result is registered. The count, the enable, the reset request, the interrupt and the sticky flag each change on the clock edge that takes the offending write or tick, and they are visible one edge after the stimulus. A decrement after a refresh at edge E lands on edge E + 2^(DIV_LOG2+P). The bench therefore checks that the old count is still present one cycle before that edge and that the new one appears after it. A behavioural reference steps on each rising edge, the outputs are compared against it on every falling edge, and directed checks sample at the computed cycle counts.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int CNT_W  = 7;
  localparam int PSC_W  = 2;
  localparam int DATA_W = CNT_W + PSC_W;

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_EDGE = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_WARN = CNT_EDGE + 1'b1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } wd_sel_e;
endpackage

// File: rtl/wd_timebase.sv
module wd_timebase
  import wd_pkg::*;
#(
  parameter int DIV_LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = DIV_LOG2 + (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < DIV_LOG2 + int'(psc_i));
  end

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= div_q + 1'b1;
  end

  AST_RESTART_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o); // R4
endmodule

// File: rtl/wd_counter.sv
module wd_counter
  import wd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              refresh_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  win_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              en_o,
  output logic              fault_o,
  output logic              warn_o
);
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [PSC_W-1:0] psc_q;
  logic             en_q;
  logic             step, too_early, bad_load, expire;

  assign step      = en_q && tick_i && !refresh_i;
  assign too_early = en_q && refresh_i && (cnt_q > win_q);
  assign bad_load  = en_q && refresh_i && !data_i[CNT_W-1];
  assign expire    = step && (cnt_q == CNT_EDGE);
  assign fault_o   = too_early || bad_load || expire;
  assign warn_o    = step && (cnt_q == CNT_WARN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_MAX;
      en_q  <= 1'b0;
    end else if (refresh_i) begin
      cnt_q <= data_i[CNT_W-1:0];
      if (data_i[CNT_W]) en_q <= 1'b1;  // set-only
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= CNT_MAX;
      psc_q <= '0;
    end else if (cfg_wr_i) begin
      win_q <= data_i[CNT_W-1:0];
      psc_q <= data_i[DATA_W-1:CNT_W];
    end
  end

  assign cnt_o = cnt_q;
  assign win_o = win_q;
  assign psc_o = psc_q;
  assign en_o  = en_q;

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !refresh_i && !tick_i) |=> $stable(cnt_q)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !refresh_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/wd_status.sv
module wd_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic fault_i,
  input  logic warn_i,
  input  logic irq_clr_i,
  input  logic flag_clr_i,
  input  logic ack_i,
  output logic irq_o,
  output logic req_o,
  output logic flag_o
);
  logic irq_q, req_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (warn_i)         irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (fault_i)        req_q <= 1'b1;
      else if (ack_i)     req_q <= 1'b0;
    end
  end

  // survives system reset; only power-on or software clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         flag_q <= 1'b0;
    else if (fault_i)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign irq_o  = irq_q;
  assign req_o  = req_q;
  assign flag_o = flag_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q); // R8
  AST_FLAG_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    fault_i |=> (req_q && flag_q)); // R10
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wd_pkg::*;
#(
  parameter int DIV_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rst_ack_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              enabled_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              wdg_rst_flag_o
);
  logic             refresh, cfg_wr, stat_wr;
  logic             tick, fault, warn;
  logic [CNT_W-1:0] win;
  logic [PSC_W-1:0] psc;

  assign refresh = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign cfg_wr  = wr_en_i && (wr_sel_i == SEL_CFG);
  assign stat_wr = wr_en_i && (wr_sel_i == SEL_STAT);

  wd_timebase #(.DIV_LOG2(DIV_LOG2)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (enabled_o),
    .restart_i (refresh),
    .psc_i     (psc),
    .tick_o    (tick)
  );

  wd_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .refresh_i (refresh),
    .cfg_wr_i  (cfg_wr),
    .data_i    (wr_data_i),
    .tick_i    (tick),
    .cnt_o     (count_o),
    .win_o     (win),
    .psc_o     (psc),
    .en_o      (enabled_o),
    .fault_o   (fault),
    .warn_o    (warn)
  );

  wd_status u_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .fault_i    (fault),
    .warn_i     (warn),
    .irq_clr_i  (stat_wr && !wr_data_i[0]),
    .flag_clr_i (stat_wr && wr_data_i[1]),
    .ack_i      (rst_ack_i),
    .irq_o      (irq_o),
    .req_o      (rst_req_o),
    .flag_o     (wdg_rst_flag_o)
  );

  AST_TIMEOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && tick && !refresh && count_o == CNT_EDGE) |=> (rst_req_o && count_o == CNT_EDGE - 1'b1)); // R5
  AST_EARLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && refresh && count_o > win) |=> rst_req_o); // R6
  AST_BAD_LOAD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && refresh && !wr_data_i[CNT_W-1]) |=> rst_req_o); // R7
  AST_WARN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && tick && !refresh && count_o == CNT_WARN) |=> irq_o); // R8
endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam int DL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       wr_en = 1'b0, ack = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [8:0] wr_data = '0;
  logic [6:0] count;
  logic       en, irq, req, flag;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  win_watchdog #(.DIV_LOG2(DL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rst_ack_i(ack), .count_o(count), .enabled_o(en),
    .irq_o(irq), .rst_req_o(req), .wdg_rst_flag_o(flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped on each rising edge
  int m_cnt, m_win, m_psc, m_div, m_en, m_irq, m_req, m_flag, m_ok;
  int period;
  bit tick, ev;
  initial begin
    m_cnt = 127; m_win = 127; m_psc = 0; m_div = 0; m_en = 0;
    m_irq = 0; m_req = 0; m_flag = 0; m_ok = 0;
  end

  always @(posedge clk) begin
    if (!por_n) m_flag = 0;
    if (!rst_n) begin
      m_en = 0; m_cnt = 127; m_win = 127; m_psc = 0; m_div = 0;
      m_irq = 0; m_req = 0; m_ok = 0;
    end else begin
      period = 1 << (DL + m_psc);
      tick = (m_en != 0) && ((m_div % period) == period - 1);
      ev = 0;
      if (wr_en && wr_sel == 2 && !wr_data[0]) m_irq = 0;
      if (wr_en && wr_sel == 0) begin
        if (m_en != 0 && (m_cnt > m_win || !wr_data[6])) ev = 1;
        m_cnt = int'(wr_data[6:0]);
        m_div = 0;
        if (wr_data[7]) m_en = 1;
      end else begin
        if (tick) begin
          if (m_cnt == 64) ev = 1;
          if (m_cnt == 65) m_irq = 1;
          m_cnt = (m_cnt - 1) & 127;
        end
        if (m_en != 0) m_div = (m_div + 1) % (1 << (DL + 3));
      end
      if (wr_en && wr_sel == 1) begin
        m_win = int'(wr_data[6:0]);
        m_psc = int'(wr_data[8:7]);
      end
      if (ev) m_req = 1;
      else if (ack) m_req = 0;
      if (por_n) begin
        if (ev) m_flag = 1;
        else if (wr_en && wr_sel == 2 && wr_data[1]) m_flag = 0;
      end
      m_ok = por_n ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (m_ok != 0 && rst_n && por_n) begin
      chk("R3 model count", int'(count), m_cnt);
      chk("R2 model enable", int'(en), m_en);
      chk("R8 model irq", int'(irq), m_irq);
      chk("R9 model req", int'(req), m_req);
      chk("R10 model flag", int'(flag), m_flag);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [8:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic sys_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count), 'h7F);
    chk("R1 enable", int'(en), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 req", int'(req), 0);
    chk("R10 flag after power-on", int'(flag), 0);

    repeat (100) @(negedge clk);
    chk("R11 no tick while disabled", int'(count), 'h7F);
    wr(2'd0, 9'h050);
    chk("R11 load while disabled", int'(count), 'h50);
    chk("R11 no req while disabled", int'(req), 0);
    repeat (50) @(negedge clk);
    chk("R11 still holding", int'(count), 'h50);

    wr(2'd0, 9'h0FF);
    chk("R2 enabled", int'(en), 1);
    wr(2'd0, 9'h07F);
    chk("R2 stays enabled", int'(en), 1);
    chk("R6 refresh at window top", int'(req), 0);

    wr(2'd0, 9'h070);
    repeat (7) @(negedge clk);
    chk("R4 no step before full period", int'(count), 'h70);
    @(negedge clk);
    chk("R3 step at period 8", int'(count), 'h6F);
    repeat (4) @(negedge clk);
    wr(2'd0, 9'h070);
    repeat (7) @(negedge clk);
    chk("R4 timebase restarted", int'(count), 'h70);
    @(negedge clk);
    chk("R4 step after restart", int'(count), 'h6F);

    wr(2'd1, {2'b01, 7'h7F});
    wr(2'd0, 9'h070);
    repeat (15) @(negedge clk);
    chk("R3 prescaler 2 hold", int'(count), 'h70);
    @(negedge clk);
    chk("R3 prescaler 2 step", int'(count), 'h6F);

    wr(2'd1, {2'b10, 7'h7F});
    wr(2'd0, 9'h045);
    repeat (159) @(negedge clk);
    chk("R8 before warning count", int'(count), 'h41);
    chk("R8 before warning irq", int'(irq), 0);
    @(negedge clk);
    chk("R8 warning count", int'(count), 'h40);
    chk("R8 warning irq", int'(irq), 1);
    chk("R5 no req at 0x40", int'(req), 0);
    wr(2'd2, 9'h001);
    chk("R8 write 1 ignored", int'(irq), 1);
    wr(2'd2, 9'h000);
    chk("R8 cleared", int'(irq), 0);
    wr(2'd0, 9'h07F);
    chk("R6 refresh at 0x40 accepted", int'(req), 0);

    wr(2'd1, {2'b00, 7'h7F});
    wr(2'd0, 9'h042);
    repeat (16) @(negedge clk);
    chk("R8 irq at 0x40", int'(irq), 1);
    repeat (7) @(negedge clk);
    chk("R5 still 0x40", int'(count), 'h40);
    chk("R5 no req yet", int'(req), 0);
    @(negedge clk);
    chk("R5 count 0x3F", int'(count), 'h3F);
    chk("R5 req raised", int'(req), 1);
    chk("R10 flag set", int'(flag), 1);
    repeat (5) @(negedge clk);
    chk("R9 req held", int'(req), 1);
    ack_pulse();
    chk("R9 req released", int'(req), 0);

    sys_reset();
    chk("R1 enable after reset", int'(en), 0);
    chk("R1 count after reset", int'(count), 'h7F);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R10 flag survives reset", int'(flag), 1);
    wr(2'd2, 9'h002);
    chk("R10 software clear", int'(flag), 0);

    wr(2'd1, {2'b00, 7'h50});
    wr(2'd0, 9'h0FF);
    chk("R6 enabling write no req", int'(req), 0);
    wr(2'd0, 9'h07F);
    chk("R6 early refresh req", int'(req), 1);
    chk("R10 flag on early refresh", int'(flag), 1);
    ack_pulse();
    sys_reset();

    wr(2'd1, {2'b00, 7'h50});
    wr(2'd0, 9'h0FF);
    repeat (400) @(negedge clk);
    wr(2'd0, 9'h07F);
    chk("R6 in-window refresh accepted", int'(req), 0);
    chk("R4 reload value", int'(count), 'h7F);

    wr(2'd1, {2'b00, 7'h7F});
    wr(2'd0, 9'h030);
    chk("R7 bit6 clear load", int'(req), 1);
    ack_pulse();
    sys_reset();

    @(negedge clk); #1 por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R10 power-on clears flag", int'(flag), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule